// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in, first-out buffer of 36-bit words whose write side and read side run on unrelated clocks. A dual-clock RAM holds the words. Each side owns its pointer and sees the other side's pointer through a Gray-coded two-flop synchronizer. The block drives five status outputs: a full or input-ready pin, an empty or output-ready pin, a half-full pin, and two threshold pins that warn of a nearly empty or nearly full buffer.

A master reset samples two configuration inputs. The first chooses standard timing or fall-through timing. The second chooses whether the two threshold pins update synchronously or asynchronously. A partial reset returns the buffer to empty and keeps the configuration that master reset captured. The two threshold offsets come in as quasi-static inputs from a separate programming block. The almost-empty offset counts words up from the empty end, and the almost-full offset counts words down from the full end.

In standard timing a word is taken only when `rd_en` is asserted. In fall-through timing the oldest word is presented on `rd_data` without a request, and `rd_en` acknowledges that word. The memory holds `DEPTH` words and the fall-through output register adds one more. The fill counts used by the flags cover the memory only.

Top module: `dcfifo_pflag`

## Requirements
- R1: After master reset with standard timing selected, and once the synchronizers have settled, the outputs are: `empty_or`=1, `full_ir`=0, `half_full`=0, `almost_empty`=1, `almost_full`=0, `rd_data`=0.
- R2: In standard timing, words come out in write order. `rd_data` takes the next word on the read-clock edge that samples `rd_en`=1 while words are present. A read request while the buffer is empty leaves `rd_data` unchanged and `empty_or` at 1.
- R3: In standard timing, `full_ir` rises to 1 after `DEPTH` words are written with no reads. A write attempted while full is dropped, and the words read back afterwards are exactly the first `DEPTH` words.
- R4: `half_full` is 1 exactly when the memory fill level, as seen by the write side, is greater than `DEPTH/2`.
- R5: With fall-through timing (`cfg_fwft`=1 at master reset), the first word written into an empty buffer appears on `rd_data` without `rd_en`, and `empty_or` (output ready) goes to 1. Asserting `rd_en` replaces the word with the next one. When no word remains, `empty_or` falls to 0.
- R6: In fall-through timing, `full_ir` means input ready. It is 1 while space remains and falls to 0 once the memory holds `DEPTH` words in addition to the word in the output register.
- R7: Partial reset empties the buffer (`empty_or` goes to 0 in fall-through timing) and keeps the timing mode captured at master reset.
- R8: In synchronous mode, `almost_empty` is 1 exactly when the fill level seen by the read side is at most `ae_off`.
- R9: In synchronous mode, `almost_full` is 1 exactly when the fill level seen by the write side is at least `DEPTH - af_off`.
- R10: With `cfg_async`=1 at master reset, both threshold flags compare the two live pointers directly. `almost_empty` falls right after the write-clock edge that raises the fill above `ae_off`. `almost_full` rises right after the write-clock edge that reaches the threshold, and falls right after the read-clock edge that drops below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, synchronous in each domain; captures configuration |
| prst | input | 1 | Partial reset, active high; empties the buffer and keeps configuration |
| cfg_fwft | input | 1 | Timing select sampled at master reset: 1 = fall-through |
| cfg_async | input | 1 | Threshold-flag timing sampled at master reset: 1 = asynchronous |
| ae_off | input | AW | Almost-empty offset from the empty end |
| af_off | input | AW | Almost-full offset from the full end |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write word |
| rd_en | input | 1 | Read request or acknowledge |
| rd_data | output | 36 | Read word |
| full_ir | output | 1 | Full (standard) or input ready (fall-through) |
| empty_or | output | 1 | Empty (standard) or output ready (fall-through) |
| half_full | output | 1 | Fill above half depth |
| almost_empty | output | 1 | Fill at or below the empty-side threshold |
| almost_full | output | 1 | Fill at or above the full-side threshold |

## Verification
The hardest case to reach is the asynchronous threshold mode. There, a flag must change within the same half period as the edge of the clock that moved a pointer, before any synchronizer could have carried that change across. The stimulus reaches this case in three steps. It drives writes and reads on the falling edge of each clock. It chooses clock periods whose write-side falling edges never coincide with read-side rising edges. It samples the flag at the first falling edge after the moving edge, a point where a synchronized version would still hold its old value. Fall-through capacity is also reached on purpose: the bench lets the first word settle into the output register before it fills the memory.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int DATA_W = 36;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic fwft;
        logic async_flags;
    } cfg_t;

endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] gray_in,
    output logic [N-1:0] bin_out
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    assign bin_out[N-1] = sync_q[N-1];
    for (genvar i = N - 2; i >= 0; i--) begin : g_conv
        assign bin_out[i] = bin_out[i+1] ^ sync_q[i];
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem
    import dcf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    localparam int WORDS = 1 << AW;

    word_t store [WORDS];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5
) (
    input  logic          wclk,
    input  logic          mrst,
    input  logic          prst,
    input  cfg_t          cfg_in,
    input  logic [AW-1:0] af_off,
    input  logic          wr_en,
    input  logic [CW-1:0] rs_bin,
    output logic [CW-1:0] w_bin,
    output logic [CW-1:0] w_gray,
    output cfg_t          cfg,
    output logic          full,
    output logic          hf,
    output logic          af_sync,
    output logic          we
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

    logic [CW-1:0] fill;
    logic [CW-1:0] af_thr;
    logic [CW-1:0] w_bin_nxt;

    assign fill      = w_bin - rs_bin;
    assign full      = (fill == DEPTH_C);
    assign we        = wr_en && !full;
    assign af_thr    = DEPTH_C - CW'(af_off);
    assign w_bin_nxt = we ? w_bin + 1'b1 : w_bin;

    always_ff @(posedge wclk) begin
        if (mrst) cfg <= cfg_in;
    end

    always_ff @(posedge wclk) begin
        if (mrst || prst) begin
            w_bin   <= '0;
            w_gray  <= '0;
            hf      <= 1'b0;
            af_sync <= 1'b0;
        end else begin
            w_bin   <= w_bin_nxt;
            w_gray  <= w_bin_nxt ^ (w_bin_nxt >> 1);
            hf      <= fill > HALF_C;
            af_sync <= fill >= af_thr;
        end
    end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int AW = 4,
    parameter int CW = 5
) (
    input  logic          rclk,
    input  logic          mrst,
    input  logic          prst,
    input  cfg_t          cfg_in,
    input  logic [AW-1:0] ae_off,
    input  logic          rd_en,
    input  logic [CW-1:0] ws_bin,
    input  word_t         mem_q,
    output logic [CW-1:0] r_bin,
    output logic [CW-1:0] r_gray,
    output cfg_t          cfg,
    output logic          empty,
    output logic          out_valid,
    output word_t         rd_q,
    output logic          ae_sync
);
    logic          take;
    logic [CW-1:0] r_bin_nxt;
    logic [CW-1:0] fill;

    assign empty = (r_bin == ws_bin);
    assign fill  = ws_bin - r_bin;

    always_comb begin
        if (cfg.fwft) take = !empty && (!out_valid || rd_en);
        else          take = !empty && rd_en;
    end

    assign r_bin_nxt = take ? r_bin + 1'b1 : r_bin;

    always_ff @(posedge rclk) begin
        if (mrst) cfg <= cfg_in;
    end

    always_ff @(posedge rclk) begin
        if (mrst || prst) begin
            r_bin     <= '0;
            r_gray    <= '0;
            rd_q      <= '0;
            out_valid <= 1'b0;
            ae_sync   <= 1'b1;
        end else begin
            r_bin   <= r_bin_nxt;
            r_gray  <= r_bin_nxt ^ (r_bin_nxt >> 1);
            ae_sync <= fill <= CW'(ae_off);
            if (take) begin
                rd_q      <= mem_q;
                out_valid <= 1'b1;
            end else if (rd_en) begin
                out_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
    import dcf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          cfg_fwft,
    input  logic          cfg_async,
    input  logic [AW-1:0] ae_off,
    input  logic [AW-1:0] af_off,
    input  logic          wr_en,
    input  logic [35:0]   wr_data,
    input  logic          rd_en,
    output logic [35:0]   rd_data,
    output logic          full_ir,
    output logic          empty_or,
    output logic          half_full,
    output logic          almost_empty,
    output logic          almost_full
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    cfg_t          cfg_req;
    cfg_t          cfg_w;
    cfg_t          cfg_r;
    logic [CW-1:0] w_bin, w_gray, rs_bin;
    logic [CW-1:0] r_bin, r_gray, ws_bin;
    logic          full, hf, af_sync, we;
    logic          empty, out_valid, ae_sync;
    word_t         mem_q;
    word_t         rd_q;
    logic [CW-1:0] live_fill;
    logic          ae_async, af_async;

    assign cfg_req = '{fwft: cfg_fwft, async_flags: cfg_async};

    dcf_gray_sync #(.N(CW)) u_sync_r2w (
        .clk(wclk), .rst(mrst || prst), .gray_in(r_gray), .bin_out(rs_bin)
    );

    dcf_gray_sync #(.N(CW)) u_sync_w2r (
        .clk(rclk), .rst(mrst || prst), .gray_in(w_gray), .bin_out(ws_bin)
    );

    dcf_wr_side #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wr (
        .wclk(wclk), .mrst(mrst), .prst(prst), .cfg_in(cfg_req),
        .af_off(af_off), .wr_en(wr_en), .rs_bin(rs_bin),
        .w_bin(w_bin), .w_gray(w_gray), .cfg(cfg_w), .full(full),
        .hf(hf), .af_sync(af_sync), .we(we)
    );

    dcf_mem #(.AW(AW)) u_mem (
        .wclk(wclk), .we(we), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
        .raddr(r_bin[AW-1:0]), .rdata(mem_q)
    );

    dcf_rd_side #(.AW(AW), .CW(CW)) u_rd (
        .rclk(rclk), .mrst(mrst), .prst(prst), .cfg_in(cfg_req),
        .ae_off(ae_off), .rd_en(rd_en), .ws_bin(ws_bin), .mem_q(mem_q),
        .r_bin(r_bin), .r_gray(r_gray), .cfg(cfg_r), .empty(empty),
        .out_valid(out_valid), .rd_q(rd_q), .ae_sync(ae_sync)
    );

    // Live pointer difference: moves on whichever clock moved a pointer.
    assign live_fill = w_bin - r_bin;
    assign ae_async  = live_fill <= CW'(ae_off);
    assign af_async  = live_fill >= (DEPTH_C - CW'(af_off));

    assign rd_data      = rd_q;
    assign full_ir      = cfg_w.fwft ? !full : full;
    assign empty_or     = cfg_r.fwft ? out_valid : empty;
    assign half_full    = hf;
    assign almost_empty = cfg_r.async_flags ? ae_async : ae_sync;
    assign almost_full  = cfg_w.async_flags ? af_async : af_sync;
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker
    import dcf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          wclk,
    input logic          rclk,
    input logic          mrst,
    input logic          prst,
    input logic          rd_en,
    input logic          full_ir,
    input logic          empty_or,
    input logic [CW-1:0] w_bin,
    input logic [CW-1:0] rs_bin,
    input logic [CW-1:0] r_bin,
    input cfg_t          cfg_w,
    input cfg_t          cfg_r
);
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (mrst || prst)
        (w_bin - rs_bin) <= CW'(DEPTH)) else $error("overflow"); // R3

    AST_FULL_BLOCKS_WRITE: assert property (@(posedge wclk) disable iff (mrst || prst)
        (!cfg_w.fwft && full_ir) |=> $stable(w_bin)) else $error("write while full"); // R3

    AST_EMPTY_BLOCKS_READ: assert property (@(posedge rclk) disable iff (mrst || prst)
        (!cfg_r.fwft && empty_or) |=> $stable(r_bin)) else $error("read while empty"); // R2

    AST_READY_HOLDS: assert property (@(posedge rclk) disable iff (mrst || prst)
        (cfg_r.fwft && empty_or && !rd_en) |=> empty_or) else $error("ready dropped"); // R5

    AST_PARTIAL_CLEARS: assert property (@(posedge wclk) disable iff (mrst)
        prst |=> (w_bin == '0)) else $error("pointer kept"); // R7

    AST_MODE_KEPT: assert property (@(posedge wclk) disable iff (mrst)
        prst |=> $stable(cfg_w)) else $error("mode lost"); // R7
endmodule

bind dcfifo_pflag dcf_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .rd_en(rd_en),
    .full_ir(full_ir), .empty_or(empty_or), .w_bin(w_bin), .rs_bin(rs_bin),
    .r_bin(r_bin), .cfg_w(cfg_w), .cfg_r(cfg_r)
);

// File: tb/dcfifo_pflag_test.sv
`timescale 1ns/1ps
module dcfifo_pflag_test;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic wclk = 0, rclk = 0;
    logic mrst = 0, prst = 0, cfg_fwft = 0, cfg_async = 0;
    logic [AW-1:0] ae_off = 0, af_off = 0;
    logic wr_en = 0, rd_en = 0;
    logic [35:0] wr_data = 0;
    logic [35:0] rd_data;
    logic full_ir, empty_or, half_full, almost_empty, almost_full;

    int checks = 0;
    int errors = 0;

    always #4 wclk = ~wclk;   // 125 MHz write clock
    always #5 rclk = ~rclk;   // read clock

    dcfifo_pflag #(.DEPTH(DEPTH)) uut (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
        .cfg_fwft(cfg_fwft), .cfg_async(cfg_async),
        .ae_off(ae_off), .af_off(af_off), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full_ir(full_ir),
        .empty_or(empty_or), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic master_reset(input logic fwft, input logic asy);
        @(negedge wclk);
        mrst = 1; cfg_fwft = fwft; cfg_async = asy;
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        mrst = 0;
    endtask

    task automatic partial_reset();
        @(negedge wclk);
        prst = 1;
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        prst = 0;
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
        repeat (8) @(negedge wclk);
    endtask

    task automatic push(input logic [35:0] d);
        @(negedge wclk);
        wr_en = 1; wr_data = d;
        @(negedge wclk);
        wr_en = 0;
    endtask

    task automatic pop();
        @(negedge rclk);
        rd_en = 1;
        @(negedge rclk);
        rd_en = 0;
    endtask

    task automatic test_reset_state();
        ae_off = 4'd2; af_off = 4'd2;
        master_reset(0, 0);
        settle();
        chk("R1 empty_or", {35'd0, empty_or}, 36'd1);
        chk("R1 full_ir", {35'd0, full_ir}, 36'd0);
        chk("R1 half_full", {35'd0, half_full}, 36'd0);
        chk("R1 almost_empty", {35'd0, almost_empty}, 36'd1);
        chk("R1 almost_full", {35'd0, almost_full}, 36'd0);
        chk("R1 rd_data", rd_data, 36'd0);
    endtask

    task automatic test_standard_fill();
        logic [35:0] base = 36'hA_0000_0000;
        for (int i = 0; i < 2; i++) push(base + 36'(i));
        settle();
        chk("R8 ae at fill 2", {35'd0, almost_empty}, 36'd1);
        push(base + 36'd2);
        settle();
        chk("R8 ae at fill 3", {35'd0, almost_empty}, 36'd0);
        for (int i = 3; i < 8; i++) push(base + 36'(i));
        settle();
        chk("R4 hf at fill 8", {35'd0, half_full}, 36'd0);
        push(base + 36'd8);
        settle();
        chk("R4 hf at fill 9", {35'd0, half_full}, 36'd1);
        for (int i = 9; i < 13; i++) push(base + 36'(i));
        settle();
        chk("R9 af at fill 13", {35'd0, almost_full}, 36'd0);
        push(base + 36'd13);
        settle();
        chk("R9 af at fill 14", {35'd0, almost_full}, 36'd1);
        chk("R3 not full at 14", {35'd0, full_ir}, 36'd0);
        push(base + 36'd14);
        push(base + 36'd15);
        settle();
        chk("R3 full at 16", {35'd0, full_ir}, 36'd1);
        push(36'h0_DEAD_BEEF);
        settle();
        for (int i = 0; i < DEPTH; i++) begin
            pop();
            chk("R2 R3 read order", rd_data, base + 36'(i));
            if (i == 7) begin
                settle();
                chk("R4 hf at fill 8 after reads", {35'd0, half_full}, 36'd0);
            end
        end
        settle();
        chk("R2 empty after drain", {35'd0, empty_or}, 36'd1);
        pop();
        chk("R2 read on empty ignored", rd_data, base + 36'd15);
    endtask

    task automatic test_fwft();
        master_reset(1, 0);
        settle();
        chk("R5 not ready at reset", {35'd0, empty_or}, 36'd0);
        chk("R6 input ready at reset", {35'd0, full_ir}, 36'd1);
        push(36'h1_1111_1111);
        settle();
        chk("R5 ready without rd_en", {35'd0, empty_or}, 36'd1);
        chk("R5 first word falls through", rd_data, 36'h1_1111_1111);
        push(36'h2_2222_2222);
        push(36'h3_3333_3333);
        settle();
        chk("R5 head word held", rd_data, 36'h1_1111_1111);
        pop();
        chk("R5 second word", rd_data, 36'h2_2222_2222);
        pop();
        chk("R5 third word", rd_data, 36'h3_3333_3333);
        pop();
        chk("R5 not ready when drained", {35'd0, empty_or}, 36'd0);
        push(36'h4_0000_0000);
        settle();
        for (int i = 1; i <= DEPTH; i++) push(36'h4_0000_0000 + 36'(i));
        settle();
        chk("R6 not ready with memory full", {35'd0, full_ir}, 36'd0);
        pop();
        settle();
        chk("R6 ready after one read", {35'd0, full_ir}, 36'd1);
        chk("R6 next word after read", rd_data, 36'h4_0000_0001);
    endtask

    task automatic test_partial_reset();
        partial_reset();
        settle();
        chk("R7 emptied by partial reset", {35'd0, empty_or}, 36'd0);
        chk("R7 ready after partial reset", {35'd0, full_ir}, 36'd1);
        push(36'h5_5555_5555);
        settle();
        chk("R7 fall-through kept", {35'd0, empty_or}, 36'd1);
        chk("R7 fall-through data", rd_data, 36'h5_5555_5555);
    endtask

    task automatic test_async_flags();
        ae_off = 4'd0; af_off = 4'd2;
        master_reset(0, 1);
        settle();
        chk("R10 ae at reset", {35'd0, almost_empty}, 36'd1);
        push(36'h6_0000_0000);
        chk("R10 ae falls on write edge", {35'd0, almost_empty}, 36'd0);
        for (int i = 1; i < 13; i++) push(36'h6_0000_0000 + 36'(i));
        chk("R10 af low at 13", {35'd0, almost_full}, 36'd0);
        push(36'h6_0000_000D);
        chk("R10 af rises on write edge", {35'd0, almost_full}, 36'd1);
        settle();
        pop();
        chk("R10 af falls on read edge", {35'd0, almost_full}, 36'd0);
        chk("R10 read data", rd_data, 36'h6_0000_0000);
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        test_reset_state();
        test_standard_fill();
        test_fwft();
        test_partial_reset();
        test_async_flags();
        finish_run();
    end
endmodule